// File: doc/BRIEF.md
# Programmable Third-Order Decimation Filter

This block turns a one-bit oversampled bitstream into wide signed words. Each modulator bit becomes +1 or -1. The values pass through three cascaded running-sum stages that run at the modulator rate. Three differencing stages then run once per output word. The overall response is a cubed sin(x)/x shape, and its first notch falls at the output word rate.

An 11-bit rate code sets the decimation ratio to four times the code. The output word rate is therefore the master clock divided by 512 times the code, because the modulator rate is the master clock divided by 128. The legal codes run from 10 to 2047, and any smaller code is treated as 10.

The filter restarts after a reset, while the active-low sync input is low, and on any change of the effective code. After a restart, the first two words are discarded because their windows still reach into the cleared history. The third word is the first one marked valid, and a settled flag then stays high until the next restart.

Top module: `sinc3_decimator`

## Requirements
- R1: A one on `mod_bit` counts as +1 and a zero as -1. With a constant input and decimation ratio N = 4 x code, every valid word equals +N^3 for all ones and -N^3 for all zeros.
- R2: With `mod_en` high on every cycle, consecutive valid words are exactly N samples apart.
- R3: A rate code below 10 behaves exactly like code 10. Changing between two codes that both clamp to 10 does not restart the filter.
- R4: For any input pattern that repeats every 4 samples with k ones, each valid word equals N^3 x (2k - 4) / 4.
- R5: After a restart, the first two words are suppressed. The first word with `result_valid` high comes no earlier than 3N samples after the restart, and no later than 3N + 2 samples after it. `settled` is still low during that word.
- R6: While `sync_n` is low, all filter state is cleared. From the next cycle on, `result_valid` and `settled` stay low.
- R7: A change of the effective rate code restarts the filter. `settled` is low on the following cycle, and the new ratio takes effect from the restart.
- R8: After reset, `result_valid`, `settled` and `result` are zero. `settled` rises on the cycle after the first valid word and stays high until a restart.
- R9: The running sums wrap modulo 2^40, and the results are still exact at code 2047 (N = 8188), where the value reaches about ±5.49e11.
- R10: Cycles with `mod_en` low have no effect on the filter. A gapped stream gives the same valid words as a continuous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | High on cycles that carry a modulator bit |
| mod_bit | input | 1 | Modulator output bit |
| rate_code | input | 11 | Rate code; decimation ratio is 4 x code, clamped at 10 |
| sync_n | input | 1 | Active-low restart request |
| result | output | 40 | Filtered signed word, two's complement |
| result_valid | output | 1 | One-cycle strobe for a settled word on `result` |
| settled | output | 1 | High once a valid word has been produced since the last restart |

## Verification
The filter is driven with four-sample periodic patterns: all ones, all zeros, three ones in four, and alternating bits. Because N is always a multiple of four, the expected word does not depend on the phase of the pattern. The all-ones and all-zeros cases separate the sign mapping from the scaling, the three-in-four case exposes any error in the weighting of the three stages, and the alternating case must cancel to exactly zero. A gapped enable pattern is checked against the same expected value, which shows that idle cycles are ignored. Runs at codes 3, 10, 12, 20, 25 and 2047 cover the clamp, the word spacing, the settling delay and the wraparound of the running sums.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
   // Modulator samples consumed per unit of the rate code.
   localparam int unsigned SAMPLES_PER_CODE = 4;

   function automatic int unsigned clamp_code(input int unsigned code,
                                              input int unsigned floor_code);
      return (code < floor_code) ? floor_code : code;
   endfunction
endpackage

// File: rtl/sinc3_rate_ctrl.sv
module sinc3_rate_ctrl #(
   parameter int unsigned CODE_W   = 11,
   parameter int unsigned MIN_CODE = 10,
   parameter int unsigned CNT_W    = CODE_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_n,
   input  logic              mod_en,
   input  logic [CODE_W-1:0] rate_code,
   output logic              restart,
   output logic              take
);
   logic [CODE_W-1:0] eff_code;
   logic [CODE_W-1:0] code_q;
   logic [CNT_W-1:0]  phase_q;
   logic [CNT_W-1:0]  last_phase;

   assign eff_code   = CODE_W'(sinc3_pkg::clamp_code(32'(rate_code), MIN_CODE));
   assign last_phase = {code_q, 2'b00} - CNT_W'(1);
   assign restart    = !sync_n || (eff_code != code_q);
   assign take       = mod_en && !restart && (phase_q == last_phase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= CODE_W'(MIN_CODE);
         phase_q <= '0;
      end else begin
         code_q <= eff_code;
         if (restart)
            phase_q <= '0;
         else if (mod_en)
            phase_q <= (phase_q == last_phase) ? '0 : phase_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/sinc3_integrators.sv
module sinc3_integrators #(
   parameter int unsigned ORDER = 3,
   parameter int unsigned ACC_W = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             in_bit,
   output logic [ACC_W-1:0] acc_next
);
   logic [ACC_W-1:0] signed_in;

   // +1 for a one, -1 (all ones) for a zero
   assign signed_in = {{(ACC_W-1){~in_bit}}, 1'b1};

   for (genvar k = 0; k < ORDER; k++) begin : g_int
      logic [ACC_W-1:0] sum_q;
      logic [ACC_W-1:0] sum_n;
      if (k == 0) begin : g_head
         assign sum_n = sum_q + signed_in;
      end else begin : g_tail
         assign sum_n = sum_q + g_int[k-1].sum_n;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    sum_q <= '0;
         else if (clr)  sum_q <= '0;
         else if (step) sum_q <= sum_n;
      end
   end

   assign acc_next = g_int[ORDER-1].sum_n;
endmodule

// File: rtl/sinc3_combs.sv
module sinc3_combs #(
   parameter int unsigned ORDER = 3,
   parameter int unsigned ACC_W = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             take,
   input  logic [ACC_W-1:0] sample_in,
   output logic [ACC_W-1:0] word,
   output logic             word_stb
);
   logic [ACC_W-1:0] samp_q;
   logic             pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_q <= '0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= take && !clr;
         if (take) samp_q <= sample_in;
      end
   end

   for (genvar k = 0; k < ORDER; k++) begin : g_cmb
      logic [ACC_W-1:0] dly_q;
      logic [ACC_W-1:0] src;
      logic [ACC_W-1:0] diff;
      if (k == 0) begin : g_head
         assign src = samp_q;
      end else begin : g_tail
         assign src = g_cmb[k-1].diff;
      end
      assign diff = src - dly_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      dly_q <= '0;
         else if (clr)    dly_q <= '0;
         else if (pend_q) dly_q <= src;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word     <= '0;
         word_stb <= 1'b0;
      end else if (clr) begin
         word     <= '0;
         word_stb <= 1'b0;
      end else begin
         word_stb <= pend_q;
         if (pend_q) word <= g_cmb[ORDER-1].diff;
      end
   end
endmodule

// File: rtl/sinc3_settle.sv
module sinc3_settle #(
   parameter int unsigned ORDER = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic word_stb,
   output logic valid,
   output logic settled
);
   localparam int unsigned CW = $clog2(ORDER + 1);

   logic [CW-1:0] seen_q;

   assign valid   = word_stb && (seen_q >= CW'(ORDER - 1));
   assign settled = (seen_q == CW'(ORDER));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seen_q <= '0;
      else if (clr)
         seen_q <= '0;
      else if (word_stb && (seen_q != CW'(ORDER)))
         seen_q <= seen_q + CW'(1);
   end
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator #(
   parameter int unsigned CODE_W   = 11,
   parameter int unsigned ACC_W    = 40,
   parameter int unsigned ORDER    = 3,
   parameter int unsigned MIN_CODE = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_en,
   input  logic              mod_bit,
   input  logic [CODE_W-1:0] rate_code,
   input  logic              sync_n,
   output logic [ACC_W-1:0]  result,
   output logic              result_valid,
   output logic              settled
);
   localparam int unsigned CNT_W = CODE_W + 2;

   if (ACC_W < ORDER * CNT_W + 1) begin : g_acc_too_narrow
      $error("ACC_W too small for ORDER stages at the largest ratio");
   end
   if (MIN_CODE < 1 || MIN_CODE >= (1 << CODE_W)) begin : g_bad_floor
      $error("MIN_CODE must lie within the rate code range");
   end
   if (ORDER < 1) begin : g_bad_order
      $error("ORDER must be at least one");
   end

   logic             restart;
   logic             take;
   logic [ACC_W-1:0] integ_out;
   logic             word_stb;

   sinc3_rate_ctrl #(.CODE_W(CODE_W), .MIN_CODE(MIN_CODE), .CNT_W(CNT_W)) u_rate (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_n    (sync_n),
      .mod_en    (mod_en),
      .rate_code (rate_code),
      .restart   (restart),
      .take      (take)
   );

   sinc3_integrators #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (restart),
      .step     (mod_en),
      .in_bit   (mod_bit),
      .acc_next (integ_out)
   );

   sinc3_combs #(.ORDER(ORDER), .ACC_W(ACC_W)) u_combs (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (restart),
      .take      (take),
      .sample_in (integ_out),
      .word      (result),
      .word_stb  (word_stb)
   );

   sinc3_settle #(.ORDER(ORDER)) u_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (restart),
      .word_stb (word_stb),
      .valid    (result_valid),
      .settled  (settled)
   );
endmodule

// File: rtl/sinc3_decimator_chk.sv
module sinc3_decimator_chk #(
   parameter int unsigned CODE_W   = 11,
   parameter int unsigned ORDER    = 3,
   parameter int unsigned MIN_CODE = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mod_en,
   input logic              sync_n,
   input logic [CODE_W-1:0] rate_code,
   input logic              result_valid,
   input logic              settled
);
   logic [CODE_W-1:0] chk_code;
   logic [CODE_W-1:0] in_code;
   logic              chk_restart;
   int unsigned       run_cnt;

   assign in_code     = CODE_W'(sinc3_pkg::clamp_code(32'(rate_code), MIN_CODE));
   assign chk_restart = !sync_n || (in_code != chk_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_code <= CODE_W'(MIN_CODE);
         run_cnt  <= 0;
      end else begin
         chk_code <= in_code;
         if (chk_restart)
            run_cnt <= 0;
         else if (mod_en && run_cnt < 32'h7fff_ffff)
            run_cnt <= run_cnt + 1;
      end
   end

   AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_n |=> (!result_valid && !settled)); // R6

   AST_CODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (in_code != chk_code) |=> !settled); // R7

   AST_SETTLED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> settled); // R8

   AST_SETTLED_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(settled) |-> $past(result_valid)); // R8

   AST_WORDS_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid); // R2

   AST_FIRST_WORD_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> (run_cnt >= ORDER * sinc3_pkg::SAMPLES_PER_CODE * 32'(chk_code))); // R5
endmodule

bind sinc3_decimator sinc3_decimator_chk i_sinc3_decimator_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mod_en       (mod_en),
   .sync_n       (sync_n),
   .rate_code    (rate_code),
   .result_valid (result_valid),
   .settled      (settled)
);

// File: tb/test_sinc3_decimator.sv
module test_sinc3_decimator;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        mod_en;
   logic        mod_bit;
   logic [10:0] rate_code;
   logic        sync_n;
   logic [39:0] result;
   logic        result_valid;
   logic        settled;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   always #2 clk = ~clk;

   sinc3_decimator i_sinc3_decimator (
      .clk          (clk),
      .rst_n        (rst_n),
      .mod_en       (mod_en),
      .mod_bit      (mod_bit),
      .rate_code    (rate_code),
      .sync_n       (sync_n),
      .result       (result),
      .result_valid (result_valid),
      .settled      (settled)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         n_tests++;
         n_fail++;
         $display("FAIL R2 watchdog: got %0d cycles expected below 190000", cycles);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Restart (sync pulse or bare code change), then stream a 4-periodic pattern.
   task automatic run_case(input string req, input int code, input bit [3:0] pat,
                           input bit gapped, input bit do_sync, input int nwords);
      int     eff;
      longint n, expv, samples, prev;
      int     words, cyc;
      bit     just;
      eff  = (code < 10) ? 10 : code;
      n    = 4 * eff;
      expv = n * n * n * (2 * $countones(pat) - 4) / 4;
      @(negedge clk);
      rate_code = 11'(code);
      mod_en    = 1'b0;
      if (do_sync) sync_n = 1'b0;
      @(negedge clk);
      check(settled == 1'b0, do_sync ? "R6" : "R7", "settled after restart", settled, 0);
      sync_n  = 1'b1;
      samples = 0; prev = 0; words = 0; cyc = 0; just = 0;
      while (words < nwords) begin
         @(negedge clk);
         cyc++;
         if (just) begin
            check(settled == 1'b1, "R8", "settled after first word", settled, 1);
            just = 0;
         end
         if (result_valid) begin
            check($signed(result) == expv, req, "word value", $signed(result), expv);
            if (words == 0) begin
               check(settled == 1'b0, "R5", "settled during first word", settled, 0);
               just = 1;
               if (!gapped)
                  check(samples >= 3 * n && samples <= 3 * n + 2, "R5",
                        "samples before first word", samples, 3 * n);
            end else if (!gapped) begin
               check(samples - prev == n, "R2", "word spacing", samples - prev, n);
            end
            prev = samples;
            words++;
         end
         mod_en  = gapped ? (cyc % 3 != 1) : 1'b1;
         mod_bit = pat[samples % 4];
         if (mod_en) samples++;
      end
      @(negedge clk);
      mod_en = 1'b0;
      if (just) check(settled == 1'b1, "R8", "settled after first word", settled, 1);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; sync_n = 1'b1; mod_en = 1'b0; mod_bit = 1'b0; rate_code = 11'd10;
      repeat (5) @(negedge clk);
      check(result_valid == 1'b0, "R8", "reset valid", result_valid, 0);
      check(settled == 1'b0, "R8", "reset settled", settled, 0);
      check(result == '0, "R8", "reset result", $signed(result), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_sync_hold();
      run_case("R1", 10, 4'b1111, 0, 1, 1);
      @(negedge clk);
      sync_n = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         check(!result_valid && !settled, "R6", "outputs while sync low",
               {result_valid, settled}, 0);
         mod_en  = 1'b1;
         mod_bit = i[0];
      end
      mod_en = 1'b0;
      run_case("R6", 10, 4'b1111, 0, 1, 2);
   endtask

   task automatic t_clamp_same();
      run_case("R3", 10, 4'b1111, 0, 1, 1);
      @(negedge clk);
      rate_code = 11'd5;
      repeat (2) @(negedge clk);
      check(settled == 1'b1, "R3", "settled kept for clamped code", settled, 1);
      run_case("R3", 3, 4'b1111, 0, 1, 3);
      run_case("R3", 0, 4'b1111, 0, 1, 2);
   endtask

   task automatic t_code_change();
      run_case("R1", 10, 4'b1111, 0, 1, 2);
      run_case("R7", 20, 4'b1111, 0, 0, 2);
   endtask

   initial begin
      t_reset();
      run_case("R1", 10, 4'b1111, 0, 1, 4);
      run_case("R1", 10, 4'b0000, 0, 1, 3);
      run_case("R4", 25, 4'b0111, 0, 1, 3);
      run_case("R4", 25, 4'b0101, 0, 1, 3);
      run_case("R10", 12, 4'b1011, 1, 1, 3);
      t_clamp_same();
      t_sync_hold();
      t_code_change();
      run_case("R9", 2047, 4'b1111, 0, 1, 2);
      run_case("R9", 2047, 4'b0000, 0, 1, 2);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule